// File: doc/BRIEF.md
# 100 Mb/s Twisted-Pair Receive Descrambler

This block sits in the receive path of a 100 Mb/s twisted-pair physical layer, directly after the three-level line decoder. Each clock it takes one NRZ cipher-text bit and produces one plain-text bit. To do this it adds a locally generated key stream to the cipher text, modulo 2. The key comes from an 11-stage linear feedback shift register that follows the recurrence X[n] = X[n-11] XOR X[n-9]. Its period is 2047 bits, and the all-zero state never occurs.

The key generator is not seeded from a known value. It finds its own state from the received line idle, which is plain-text all ones. While hunting, the block shifts the inverse of each cipher bit into the register, so after 11 bits the register holds the key history. It then requires a run of correctly predicted idle bits before it declares lock. Once locked, the register runs freely. The block watches the plain text for runs of idle ones and drops lock if no qualifying run arrives within a set window. While unlocked, it emits all ones and holds the locked flag low.

Top module: `ds_stream_descrambler`

## Requirements
- R1: Reset leaves `locked_o` low and `plain_o` high.
- R2: Whenever `locked_o` is low, `plain_o` is 1.
- R3: After reset, given a scrambled idle stream from its first bit, `locked_o` is still low after KEY_LEN+CONFIRM_LEN-1 clock edges and is high after KEY_LEN+CONFIRM_LEN edges.
- R4: While locked, `plain_o` equals the cipher bit XOR the key bit for that bit. The output is registered, so the result appears one clock after the cipher bit is sampled, with no bit lost or repeated.
- R5: The key bit is X[n] = X[n-11] XOR X[n-9] over the previous key bits. The 11-bit key register is never all zeros while locked.
- R6: A constant all-ones cipher stream, which matches idle under a zero key, never produces lock.
- R7: While locked, a plain-text run of at least IDLE_RUN consecutive ones restarts the lock window. Data gaps shorter than the window between such runs keep lock.
- R8: Lock falls at the clock edge exactly WINDOW_LEN bits after the last bit that completed a qualifying idle run. A burst of random cipher bits longer than the window therefore removes lock.
- R9: A run of IDLE_RUN-1 ones does not restart the window. A run of exactly IDLE_RUN ones does.
- R10: After lock is lost, hunting starts again from an empty register. Lock returns within KEY_LEN+CONFIRM_LEN bits of scrambled idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cipher_i | input | 1 | NRZ cipher-text bit from the line decoder |
| plain_o | output | 1 | Recovered plain-text bit (all ones while unlocked) |
| locked_o | output | 1 | High while the key generator is synchronized |

## Verification
The bench builds the block with CONFIRM_LEN=16, IDLE_RUN=30 and WINDOW_LEN=600, instead of a window of tens of thousands of bits. At that size, window expiry, the 29-versus-30 run boundary and relocking after a long random burst all fit into a short run many times over. The key length and tap stay at 11 and 9, so the full 2047-bit sequence runs against a reference scrambler seeded with a random non-zero value. The exact lock and unlock edges are checked against counts derived from these parameters.

// File: rtl/ds_pkg.sv
`timescale 1ns/1ps
package ds_pkg;

   typedef enum logic {
      SYNC_HUNT   = 1'b0,
      SYNC_LOCKED = 1'b1
   } sync_state_e;

   // Idle plain text is all ones, so a bit matches idle when cipher ^ key is 1.
   function automatic logic is_idle_bit(input logic cipher, input logic key);
      return cipher ^ key;
   endfunction

endpackage

// File: rtl/ds_key_gen.sv
`timescale 1ns/1ps
module ds_key_gen #(
   parameter int KEY_LEN = 11,
   parameter int TAP_POS = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               track_i,
   input  logic               cipher_i,
   output logic               key_bit_o,
   output logic [KEY_LEN-1:0] state_o
);
   // sr_q[i] holds the key bit produced i+1 bits ago.
   logic [KEY_LEN-1:0] sr_q;
   logic [KEY_LEN-1:0] sr_d;
   logic               feed;

   assign key_bit_o = sr_q[KEY_LEN-1] ^ sr_q[TAP_POS-1];
   // While hunting the line is assumed idle: key = ~cipher.
   assign feed      = track_i ? ~cipher_i : key_bit_o;

   generate
      for (genvar i = 0; i < KEY_LEN; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign sr_d[i] = feed;
         end else begin : g_body
            assign sr_d[i] = sr_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '1;
      else        sr_q <= sr_d;
   end

   assign state_o = sr_q;
endmodule

// File: rtl/ds_acquire.sv
`timescale 1ns/1ps
module ds_acquire #(
   parameter int KEY_LEN     = 11,
   parameter int CONFIRM_LEN = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hunting_i,
   input  logic cipher_i,
   input  logic key_bit_i,
   input  logic state_zero_i,
   output logic gain_o
);
   import ds_pkg::*;

   localparam int LW = $clog2(KEY_LEN + 1);
   localparam int CW = $clog2(CONFIRM_LEN + 1);

   logic [LW-1:0] load_q;
   logic [CW-1:0] match_q;
   logic          loaded;
   logic          hit;

   assign loaded = (load_q == LW'(KEY_LEN));
   // A zero register would "predict" idle on an all-ones line; never trust it.
   assign hit    = loaded && !state_zero_i && is_idle_bit(cipher_i, key_bit_i);
   assign gain_o = hunting_i && hit && (match_q == CW'(CONFIRM_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !hunting_i) begin
         load_q  <= '0;
         match_q <= '0;
      end else begin
         if (!loaded) load_q <= load_q + 1'b1;
         if (hit && !gain_o) match_q <= match_q + 1'b1;
         else                match_q <= '0;
      end
   end
endmodule

// File: rtl/ds_idle_watch.sv
`timescale 1ns/1ps
module ds_idle_watch #(
   parameter int IDLE_RUN   = 30,
   parameter int WINDOW_LEN = 90250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic bit_i,
   output logic expire_o
);
   localparam int RW = $clog2(IDLE_RUN + 1);
   localparam int TW = $clog2(WINDOW_LEN);

   logic [RW-1:0] run_q;
   logic [RW-1:0] run_next;
   logic [TW-1:0] tmr_q;
   logic          qualify;

   always_comb begin
      if (!bit_i)                       run_next = '0;
      else if (run_q == RW'(IDLE_RUN))  run_next = run_q;
      else                              run_next = run_q + 1'b1;
   end

   assign qualify  = (run_next == RW'(IDLE_RUN));
   assign expire_o = active_i && !qualify && (tmr_q == TW'(WINDOW_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !active_i) begin
         run_q <= '0;
         tmr_q <= '0;
      end else begin
         run_q <= run_next;
         tmr_q <= qualify ? '0 : tmr_q + 1'b1;
      end
   end
endmodule

// File: rtl/ds_stream_descrambler.sv
`timescale 1ns/1ps
module ds_stream_descrambler #(
   parameter int KEY_LEN     = 11,
   parameter int TAP_POS     = 9,
   parameter int CONFIRM_LEN = 24,
   parameter int IDLE_RUN    = 30,
   parameter int WINDOW_LEN  = 90250,
   parameter int OUT_REG     = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cipher_i,
   output logic plain_o,
   output logic locked_o
);
   import ds_pkg::*;

   generate
      if (TAP_POS < 1 || TAP_POS >= KEY_LEN) begin : g_bad_tap
         $error("TAP_POS must lie inside the key register");
      end
      if (CONFIRM_LEN < 1) begin : g_bad_confirm
         $error("CONFIRM_LEN must be at least 1");
      end
      if (IDLE_RUN < 2 || WINDOW_LEN <= IDLE_RUN) begin : g_bad_window
         $error("WINDOW_LEN must exceed IDLE_RUN, IDLE_RUN at least 2");
      end
   endgenerate

   sync_state_e        state_q, state_d;
   logic               hunting;
   logic               key_bit;
   logic [KEY_LEN-1:0] key_state;
   logic               gain;
   logic               expire;
   logic               plain_raw;

   assign hunting   = (state_q == SYNC_HUNT);
   assign plain_raw = cipher_i ^ key_bit;

   ds_key_gen #(.KEY_LEN(KEY_LEN), .TAP_POS(TAP_POS)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .track_i  (hunting),
      .cipher_i (cipher_i),
      .key_bit_o(key_bit),
      .state_o  (key_state)
   );

   ds_acquire #(.KEY_LEN(KEY_LEN), .CONFIRM_LEN(CONFIRM_LEN)) u_acq (
      .clk         (clk),
      .rst_n       (rst_n),
      .hunting_i   (hunting),
      .cipher_i    (cipher_i),
      .key_bit_i   (key_bit),
      .state_zero_i(~|key_state),
      .gain_o      (gain)
   );

   ds_idle_watch #(.IDLE_RUN(IDLE_RUN), .WINDOW_LEN(WINDOW_LEN)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .active_i(!hunting),
      .bit_i   (plain_raw),
      .expire_o(expire)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         SYNC_HUNT:   if (gain)   state_d = SYNC_LOCKED;
         SYNC_LOCKED: if (expire) state_d = SYNC_HUNT;
         default:                 state_d = SYNC_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SYNC_HUNT;
      else        state_q <= state_d;
   end

   assign locked_o = (state_q == SYNC_LOCKED);

   generate
      if (OUT_REG != 0) begin : g_reg_out
         logic plain_q;
         // Uses the next state so the output and the flag change together.
         always_ff @(posedge clk) begin
            if (!rst_n) plain_q <= 1'b1;
            else        plain_q <= (state_d == SYNC_LOCKED) ? plain_raw : 1'b1;
         end
         assign plain_o = plain_q;
      end else begin : g_comb_out
         assign plain_o = locked_o ? plain_raw : 1'b1;
      end
   endgenerate
endmodule

// File: rtl/ds_stream_descrambler_chk.sv
`timescale 1ns/1ps
module ds_stream_descrambler_chk #(
   parameter int KEY_LEN  = 11,
   parameter int IDLE_RUN = 30,
   parameter int OUT_REG  = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               plain_o,
   input logic               locked_o,
   input logic [KEY_LEN-1:0] key_state_i
);
   localparam int RW = $clog2(IDLE_RUN + 2);

   logic [RW-1:0] run_q;
   logic [RW-1:0] run_now;

   always_comb begin
      if (!(locked_o && plain_o))           run_now = '0;
      else if (run_q == RW'(IDLE_RUN + 1))  run_now = run_q;
      else                                  run_now = run_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= run_now;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (!locked_o && plain_o));                               // R1
   AST_HUNT_EMITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !locked_o |-> plain_o);                                           // R2
   AST_LOCK_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (OUT_REG != 0 && $rose(locked_o)) |-> plain_o);                   // R3
   AST_KEY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |-> (key_state_i != '0));                                // R5
   AST_NO_ZERO_KEY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> ($past(key_state_i) != '0));                  // R6
   AST_IDLE_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_o && run_now == RW'(IDLE_RUN + 1)) |=> locked_o);         // R7
endmodule

bind ds_stream_descrambler ds_stream_descrambler_chk #(
   .KEY_LEN (KEY_LEN),
   .IDLE_RUN(IDLE_RUN),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .plain_o    (plain_o),
   .locked_o   (locked_o),
   .key_state_i(key_state)
);

// File: tb/test_ds_stream_descrambler.sv
`timescale 1ns/1ps
module test_ds_stream_descrambler;
   localparam int KLEN = 11;
   localparam int CONF = 16;
   localparam int IRUN = 30;
   localparam int WIN  = 600;

   typedef struct packed {logic val; logic care;} exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cipher = 1'b1;
   logic plain;
   logic locked;

   int n_chk = 0;
   int n_err = 0;
   logic [10:0] ref_sr;
   exp_t q[$];

   ds_stream_descrambler #(.CONFIRM_LEN(CONF), .IDLE_RUN(IRUN), .WINDOW_LEN(WIN))
      i_ds_stream_descrambler (
      .clk     (clk),
      .rst_n   (rst_n),
      .cipher_i(cipher),
      .plain_o (plain),
      .locked_o(locked)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   // Reference scrambler: key = X[n-11] ^ X[n-9], cipher = plain ^ key.
   task automatic put(input logic p);
      logic k;
      k = ref_sr[10] ^ ref_sr[8];
      ref_sr = {ref_sr[9:0], k};
      @(negedge clk);
      cipher = p ^ k;
      q.push_back(exp_t'{val: p, care: 1'b1});
   endtask

   task automatic put_raw(input logic c);
      @(negedge clk);
      cipher = c;
      q.push_back(exp_t'{val: 1'b1, care: 1'b0});
   endtask

   task automatic idle(input int n);
      repeat (n) put(1'b1);
   endtask

   task automatic settle();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      q.delete();
      @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   // Monitor: one expected item per clock edge after reset.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (locked) begin
               if (e.care) check("R4 R5 recovered data", plain, e.val);
            end else begin
               check("R2 unlocked output idle", plain, 1'b1);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      ref_sr = 11'($urandom);
      while (ref_sr == '0) ref_sr = 11'($urandom);

      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R1 reset locked", locked, 1'b0);
      check("R1 reset plain", plain, 1'b1);
      @(posedge clk);
      #2 rst_n = 1'b1;

      // R6: all-ones cipher equals idle under a zero key; must not lock
      repeat (150) put_raw(1'b1);
      settle();
      check("R6 all-ones cipher no lock", locked, 1'b0);

      // R3: exact acquisition edge
      do_reset();
      idle(KLEN + CONF - 1);
      settle();
      check("R3 not yet locked", locked, 1'b0);
      put(1'b1);
      settle();
      check("R3 locked on time", locked, 1'b1);

      // R4 / R7: random data with idle runs between, gaps below the window
      repeat (4) begin
         idle(40);
         repeat (300) put(1'($urandom_range(0, 1)));
      end
      idle(40);
      settle();
      check("R7 lock held across data", locked, 1'b1);

      // R8: non-idle plain for the window length
      repeat (WIN - 1) put(1'b0);
      settle();
      check("R8 lock before window end", locked, 1'b1);
      put(1'b0);
      settle();
      check("R8 lock dropped at window end", locked, 1'b0);
      repeat (20) put(1'b0);

      // R10: relock after loss
      idle(KLEN + CONF);
      settle();
      check("R10 relock after loss", locked, 1'b1);
      repeat (200) put(1'($urandom_range(0, 1)));
      idle(40);

      // R9: runs of IRUN-1 ones never restart the window
      for (int i = 0; i < WIN - 1; i++) put(1'((i % IRUN) != 0));
      settle();
      check("R9 short runs lock still held", locked, 1'b1);
      put(1'b1);
      settle();
      check("R9 short runs do not refresh", locked, 1'b0);

      // R9: runs of exactly IRUN ones do restart the window
      idle(KLEN + CONF + 2);
      idle(40);
      for (int i = 0; i < 2 * WIN; i++) put(1'((i % (IRUN + 1)) != 0));
      settle();
      check("R9 exact runs keep lock", locked, 1'b1);

      // R8: random cipher burst longer than the window
      repeat (WIN + 60) put_raw(1'($urandom_range(0, 1)));
      settle();
      check("R8 burst removes lock", locked, 1'b0);

      // R10: relock, then data again
      idle(KLEN + CONF);
      settle();
      check("R10 relock after burst", locked, 1'b1);
      repeat (300) put(1'($urandom_range(0, 1)));
      idle(5);
      settle();
      settle();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule